// File: doc/BRIEF.md
# SRAM DLL and Impedance Start-up Sequencer

This block sits on the controller side of a double-data-rate SRAM and brings the memory out of power-up. It holds the memory's DLL switched off while the supply or the memory clock is not yet trustworthy. Once both `pwr_good` and `clk_stable` are high it switches the DLL on. It then waits until two separate conditions hold: the DLL has seen a fixed number of memory clock cycles to lock, and the memory has seen enough cycles without a read to settle its output-driver impedance. Only then does it raise `ready` and let reads through.

The block runs on a free-running reference clock with a known period. Each memory clock cycle is reported to it by `mem_clk_tick`. A DLL reset can be requested without using the DLL-off drive, either by `stop_req` or by `freq_chg` (a new operating frequency). In both cases the sequencer drops `ready` and raises `clk_gate_req` so that the memory clock is stopped. It keeps that request until the clock has been quiet for a minimum time, measured in reference cycles. It then releases the clock and counts a fresh lock interval. Impedance calibration survives such a re-arm and is only repeated after reset. Reads asked for while the block is not ready are refused and reported with a one-cycle error pulse.

Top module: `sram_init_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `dll_run`, `clk_gate_req`, `ready`, `rd_grant` and `rd_err` are all low (with `rd_req` low).
- R2: `dll_run` stays low until `pwr_good` and `clk_stable` are sampled high together on one clock edge. It goes high right after that edge.
- R3: If `pwr_good` or `clk_stable` is sampled low on any edge, then after that edge `dll_run`, `ready` and `clk_gate_req` are low. The full start-up sequence then has to be repeated.
- R4: Only cycles with `mem_clk_tick` high, counted from the edge on which `dll_run` rises (or on which the clock gate is released), count toward lock. Ticks continuously present and impedance already settled, `ready` rises on the (LOCK_CYCLES+1)-th edge after that edge; cycles without a tick add a matching delay.
- R5: A cycle counts toward impedance settling when `mem_clk_tick` and `pwr_good` are high and `rd_req` is low. `ready` needs NONREAD_CYCLES such cycles. If lock is already complete, `ready` rises on the edge after the NONREAD_CYCLES-th counted cycle. This count is cleared only by reset and is kept across re-arms.
- R6: `ready` is high only while both the lock count and the impedance count are complete and no re-arm is pending. `ready` implies `dll_run`.
- R7: A `stop_req` sampled high while `dll_run` is high and supply and clock are good makes `clk_gate_req` high and `ready` low right after that edge.
- R8: `clk_gate_req` stays high until STOP_TICKS consecutive reference cycles without `mem_clk_tick` have passed, where STOP_TICKS = ceil(STOP_MIN_PS / REF_PERIOD_PS). A tick restarts that count. Once the count is reached, `clk_gate_req` falls on the next edge and the lock count restarts from zero.
- R9: A `freq_chg` sampled high while `dll_run` is high takes the same gate, wait and relock path as `stop_req`.
- R10: `rd_grant` equals `rd_req` while `ready` is high and is low otherwise. A `rd_req` sampled high while `ready` is low makes `rd_err` high for the following cycle only.
- R11: `stop_req` and `freq_chg` have no effect while `dll_run` is low: `clk_gate_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Memory supplies are stable |
| clk_stable | input | 1 | Memory clock source is stable |
| mem_clk_tick | input | 1 | One memory clock cycle occurred in this reference cycle |
| stop_req | input | 1 | Request a DLL reset by stopping the clock |
| freq_chg | input | 1 | Operating frequency is changing; DLL reset needed |
| rd_req | input | 1 | Controller wants to issue a read this cycle |
| dll_run | output | 1 | DLL enable drive to the memory (low = DLL off) |
| clk_gate_req | output | 1 | Request to stop the memory clock |
| ready | output | 1 | Memory may carry traffic |
| rd_grant | output | 1 | Read allowed this cycle |
| rd_err | output | 1 | Read was requested while not ready (one-cycle pulse) |

## Verification
The embedded properties watch, on every cycle, the local causal rules:
- a bad supply or clock turns the DLL off on the next edge;
- `ready` never appears without `dll_run`, and it rises only after both counts have finished;
- a refused read always produces the error pulse, and a grant never appears without `ready`;
- a re-arm drops `ready` and raises the gate at once, and the gate holds while the quiet window is not yet complete;
- the counters never run past their limits, and the impedance result never clears.

The exact lengths of the intervals can only be shown by the directed scenarios. These cover:
- the edge on which `ready` first rises, with and without gaps in the ticks;
- which of the two counts is the limiting one;
- a tick restarting the stop window;
- impedance staying settled through a relock.

// File: rtl/sq_pkg.sv
// Package: shared types and helpers of the SRAM start-up sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sq_pkg;

    // Sequencer states; order carries no meaning.
    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,   // DLL off, waiting for supply and clock
        SEQ_LOCK  = 2'd1,   // DLL on, counting lock and impedance cycles
        SEQ_READY = 2'd2,   // traffic allowed
        SEQ_STOP  = 2'd3    // memory clock stopped for a DLL reset
    } seq_state_t;

    // Integer division rounded up, used to turn a duration into a cycle count.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sq_sat_counter.sv
// Module: saturating up-counter with synchronous clear and a done flag.
// Counts enabled cycles from zero up to LIMIT and holds there.
// Assumes: LIMIT >= 1; clear has priority over increment.
module sq_sat_counter #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    // Count enabled cycles, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != LIM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);

    // The counter never passes its limit (guards R4, R5, R8 intervals).
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);

    // Once at the limit, it stays there unless cleared.
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done);

endmodule

// File: rtl/sq_read_gate.sv
// Module: read admission for the sequencer.
// Passes read requests through while ready. Otherwise it blocks them and
// raises a one-cycle error pulse on the following cycle.
// Assumes: ready is a registered signal from the sequencer state.
module sq_read_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic ready,
    output logic rd_grant,
    output logic rd_err
);
    // A grant is the request itself, qualified by readiness.
    assign rd_grant = rd_req & ready;

    // Register a refused request into an error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_err <= 1'b0;
        end else begin
            rd_err <= rd_req & ~ready;
        end
    end

    // A refused read always produces an error on the next cycle.
    assert_refused_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !ready) |=> rd_err);

    // No error follows a cycle without a refused read.
    assert_no_spurious_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && !ready) |=> !rd_err);

endmodule

// File: rtl/sram_init_seq.sv
// Module: start-up and re-arm sequencer for an attached DDR SRAM.
// Holds the DLL off until supply and clock are good. Then it counts the
// DLL lock interval and the non-read cycles needed for impedance settling,
// and then grants traffic. A clock-stop or frequency-change request stops
// the memory clock for a minimum quiet time and relocks.
// Assumes: clk is free-running with period REF_PERIOD_PS. mem_clk_tick
// marks each memory clock cycle, already brought into this clock domain.
module sram_init_seq #(
    parameter int unsigned LOCK_CYCLES    = 2048,
    parameter int unsigned NONREAD_CYCLES = 1024,
    parameter int unsigned REF_PERIOD_PS  = 8000,
    parameter int unsigned STOP_MIN_PS    = 30000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic clk_stable,
    input  logic mem_clk_tick,
    input  logic stop_req,
    input  logic freq_chg,
    input  logic rd_req,
    output logic dll_run,
    output logic clk_gate_req,
    output logic ready,
    output logic rd_grant,
    output logic rd_err
);
    import sq_pkg::*;

    localparam int unsigned STOP_TICKS = ceil_div(STOP_MIN_PS, REF_PERIOD_PS);

    seq_state_t state, state_nxt;
    logic       env_ok;
    logic       rearm;
    logic       lock_done;
    logic       imp_done;
    logic       stop_done;

    assign env_ok = pwr_good & clk_stable;
    assign rearm  = stop_req | freq_chg;

    // Lock interval: memory clock cycles spent in the lock state.
    sq_sat_counter #(.LIMIT(LOCK_CYCLES)) i_lock_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != SEQ_LOCK),
        .inc   (mem_clk_tick),
        .done  (lock_done)
    );

    // Impedance settling: non-read memory cycles with power up; kept until reset.
    sq_sat_counter #(.LIMIT(NONREAD_CYCLES)) i_imp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .inc   (mem_clk_tick & pwr_good & ~rd_req),
        .done  (imp_done)
    );

    // Quiet window: consecutive reference cycles without a memory tick while stopped.
    sq_sat_counter #(.LIMIT(STOP_TICKS)) i_stop_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state != SEQ_STOP) | mem_clk_tick),
        .inc   (1'b1),
        .done  (stop_done)
    );

    // Next-state selection; a bad environment always wins.
    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_HOLD: begin
                if (env_ok) state_nxt = SEQ_LOCK;
            end
            SEQ_LOCK: begin
                if (!env_ok)                   state_nxt = SEQ_HOLD;
                else if (rearm)                state_nxt = SEQ_STOP;
                else if (lock_done && imp_done) state_nxt = SEQ_READY;
            end
            SEQ_READY: begin
                if (!env_ok)    state_nxt = SEQ_HOLD;
                else if (rearm) state_nxt = SEQ_STOP;
            end
            SEQ_STOP: begin
                if (!env_ok)        state_nxt = SEQ_HOLD;
                else if (stop_done) state_nxt = SEQ_LOCK;
            end
            default: state_nxt = SEQ_HOLD;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_HOLD;
        else        state <= state_nxt;
    end

    // Output decode straight from the registered state.
    assign dll_run      = (state != SEQ_HOLD);
    assign clk_gate_req = (state == SEQ_STOP);
    assign ready        = (state == SEQ_READY);

    sq_read_gate i_rd_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .ready    (ready),
        .rd_grant (rd_grant),
        .rd_err   (rd_err)
    );

    // Bad supply or clock turns everything off on the next edge.
    assert_env_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !env_ok |=> (!dll_run && !ready && !clk_gate_req));

    // DLL stays off while waiting, and turns on once the environment is good.
    assert_dll_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dll_run && env_ok) |=> dll_run);

    // Ready implies DLL running and no clock gate.
    assert_ready_dll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (dll_run && !clk_gate_req));

    // Ready rises only with both counts complete on the edge before.
    assert_ready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(lock_done && imp_done));

    // Impedance result is never lost after it is reached.
    assert_imp_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        imp_done |=> imp_done);

    // A re-arm with DLL running gates the clock and drops ready next edge.
    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_run && env_ok && rearm && !clk_gate_req) |=> (clk_gate_req && !ready));

    // The gate holds while the quiet window is incomplete.
    assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_gate_req && env_ok && !stop_done) |=> clk_gate_req);

    // Re-arm requests leave the gate off while the DLL is off.
    assert_rearm_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!dll_run && !env_ok) |=> !clk_gate_req);

    // Grants never appear without ready.
    assert_grant_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> ready);

endmodule

// File: tb/test_sram_init_seq.sv
// Directed bench for the start-up sequencer: one task per scenario.
// Inputs change and outputs are sampled on the falling clock edge.
module test_sram_init_seq;
    localparam int unsigned LOCK_N = 2048;
    localparam int unsigned IMP_N  = 1024;
    localparam int unsigned STOP_N = 4;   // ceil(30000 / 8000)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, clk_stable = 1'b0, mem_clk_tick = 1'b0;
    logic stop_req = 1'b0, freq_chg = 1'b0, rd_req = 1'b0;
    logic dll_run, clk_gate_req, ready, rd_grant, rd_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sram_init_seq i_sram_init_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .clk_stable   (clk_stable),
        .mem_clk_tick (mem_clk_tick),
        .stop_req     (stop_req),
        .freq_chg     (freq_chg),
        .rd_req       (rd_req),
        .dll_run      (dll_run),
        .clk_gate_req (clk_gate_req),
        .ready        (ready),
        .rd_grant     (rd_grant),
        .rd_err       (rd_err)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pwr_good = 0; clk_stable = 0; mem_clk_tick = 0;
        stop_req = 0; freq_chg = 0; rd_req = 0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    // Bring the sequencer to ready with continuous ticks and no reads.
    task automatic bring_up();
        pwr_good = 1; clk_stable = 1; mem_clk_tick = 1;
        step(1);
        step(LOCK_N);
        step(1);
    endtask

    // R1: quiet outputs out of reset.
    task automatic t_reset_state();
        rst_n = 1'b0;
        step(2);
        check("R1", dll_run, 1'b0, "dll_run in reset");
        check("R1", ready, 1'b0, "ready in reset");
        rst_n = 1'b1;
        step(1);
        check("R1", clk_gate_req, 1'b0, "gate after reset");
        check("R1", rd_err, 1'b0, "rd_err after reset");
        check("R1", rd_grant, 1'b0, "rd_grant after reset");
    endtask

    // R2, R11: DLL stays off until both conditions; re-arm ignored while off.
    task automatic t_hold();
        do_reset();
        pwr_good = 1; mem_clk_tick = 1;
        step(20);
        check("R2", dll_run, 1'b0, "dll_run with clock unstable");
        stop_req = 1; freq_chg = 1;
        step(1);
        stop_req = 0; freq_chg = 0;
        check("R11", clk_gate_req, 1'b0, "gate after re-arm while off");
        pwr_good = 0; clk_stable = 1;
        step(5);
        check("R2", dll_run, 1'b0, "dll_run with power bad");
        pwr_good = 1;
        step(1);
        check("R2", dll_run, 1'b1, "dll_run after both good");
        check("R11", clk_gate_req, 1'b0, "gate still low");
    endtask

    // R4, R6: lock-limited start-up including a gap in the ticks.
    task automatic t_lock_gap();
        do_reset();
        pwr_good = 1; clk_stable = 1; mem_clk_tick = 1;
        step(1);
        step(1000);
        mem_clk_tick = 0;
        step(100);
        check("R4", ready, 1'b0, "ready during tick gap");
        mem_clk_tick = 1;
        step(LOCK_N - 1000);
        check("R4", ready, 1'b0, "ready one edge before lock ends");
        step(1);
        check("R4", ready, 1'b1, "ready after lock interval");
        check("R6", dll_run, 1'b1, "dll_run with ready");
    endtask

    // R5, R10: reads stall impedance settling and are refused.
    task automatic t_imp_limited();
        do_reset();
        pwr_good = 1; clk_stable = 1; mem_clk_tick = 1; rd_req = 1;
        step(1);
        check("R10", rd_err, 1'b1, "rd_err for early read");
        check("R10", rd_grant, 1'b0, "no grant before ready");
        step(LOCK_N + 50);
        check("R5", ready, 1'b0, "ready blocked by reads");
        rd_req = 0;
        step(1);
        check("R10", rd_err, 1'b0, "rd_err clears after request drops");
        step(IMP_N - 1);
        check("R5", ready, 1'b0, "ready one edge before settling");
        step(1);
        check("R5", ready, 1'b1, "ready after settling");
        rd_req = 1;
        #1;
        check("R10", rd_grant, 1'b1, "grant when ready");
        step(1);
        check("R10", rd_err, 1'b0, "no error when granted");
        rd_req = 0;
    endtask

    // R7, R8, R5: clock stop, tick restart of the window, relock with impedance kept.
    task automatic t_stop();
        do_reset();
        bring_up();
        check("R6", ready, 1'b1, "ready before stop");
        stop_req = 1;
        step(1);
        stop_req = 0;
        check("R7", clk_gate_req, 1'b1, "gate after stop request");
        check("R7", ready, 1'b0, "ready dropped on stop");
        step(6);
        check("R8", clk_gate_req, 1'b1, "gate held while ticks continue");
        mem_clk_tick = 0;
        step(STOP_N);
        check("R8", clk_gate_req, 1'b1, "gate held until window complete");
        step(1);
        check("R8", clk_gate_req, 1'b0, "gate released after window");
        mem_clk_tick = 1; rd_req = 1;
        step(LOCK_N);
        check("R8", ready, 1'b0, "relock counts from zero");
        step(1);
        check("R5", ready, 1'b1, "impedance kept across relock");
        rd_req = 0;
    endtask

    // R9: frequency change follows the stop path.
    task automatic t_freq();
        do_reset();
        bring_up();
        freq_chg = 1;
        step(1);
        freq_chg = 0; mem_clk_tick = 0;
        check("R9", clk_gate_req, 1'b1, "gate after frequency change");
        check("R9", ready, 1'b0, "ready dropped on frequency change");
        step(STOP_N);
        check("R9", clk_gate_req, 1'b1, "gate held for quiet window");
        step(1);
        check("R9", clk_gate_req, 1'b0, "gate released");
        check("R9", dll_run, 1'b1, "DLL kept running through stop");
    endtask

    // R3: supply or clock loss restarts everything.
    task automatic t_env_loss();
        do_reset();
        bring_up();
        pwr_good = 0;
        step(1);
        check("R3", dll_run, 1'b0, "dll_run after power loss");
        check("R3", ready, 1'b0, "ready after power loss");
        pwr_good = 1;
        step(1);
        check("R3", dll_run, 1'b1, "dll_run after recovery");
        check("R3", ready, 1'b0, "ready waits for new lock");
        stop_req = 1;
        step(1);
        stop_req = 0; clk_stable = 0;
        step(1);
        check("R3", clk_gate_req, 1'b0, "gate cleared by clock loss");
        check("R3", dll_run, 1'b0, "dll_run off by clock loss");
    endtask

    initial begin
        t_reset_state();
        t_hold();
        t_lock_gap();
        t_imp_limited();
        t_stop();
        t_freq();
        t_env_loss();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule